// File: doc/BRIEF.md
# Dual-Packet IN Endpoint Transmit Buffer

This block is the transmit store for one device-side IN endpoint. It keeps up to two complete packets in two slots. The processor loads bytes through a write port. The serial engine reads the oldest committed packet through a read port, one packet for each IN token. A packet becomes committed when the processor raises a commit pulse. When auto-commit is on, it also becomes committed by itself once the byte count reaches the configured maximum packet size. A packet shorter than that limit always needs an explicit commit.

Two events free the older packet: a successful-transmit pulse from the serial engine, or a flush pulse from the processor. Either one makes the newer packet current. In isochronous mode, a packet request that finds nothing committed sets a sticky underrun flag. Only a processor clear pulse, which models writing 0 to the flag, resets it. An interrupt request follows the flag when interrupts are enabled. Line coding, token decoding, CRC and bus timing are not part of this block. `MAX_BYTES` must be a power of two, at least 2.

Top module: `in_ep_pktbuf`

## Requirements
- R1: After reset, not_empty, buf_full, uflow and uflow_irq are 0 and fill_level is 0.
- R2: not_empty is 1 exactly when at least one committed packet is held. buf_full is 1 exactly when two are held.
- R3: A commit pulse closes the packet being filled with its current byte count, which includes a byte written in the same cycle. A packet shorter than the maximum stays uncommitted without a commit pulse, even with auto-commit on.
- R4: With cfg_auto_commit = 1, the write that brings the fill count equal to min(cfg_maxp, MAX_BYTES) commits the packet in that same cycle, and fill_level returns to 0.
- R5: A write is accepted only while fill_level is below min(cfg_maxp, MAX_BYTES). Other writes leave fill_level unchanged.
- R6: While two packets are held, writes and commit pulses are ignored: fill_level, buf_full and the current packet stay unchanged.
- R7: A flush with one packet held leaves the buffer empty.
- R8: A flush with two packets held discards only the older one. rd_len and rd_data then show the newer packet from its first byte.
- R9: A tx_done pulse releases the older packet. The newer one becomes current, in commit order.
- R10: rd_data is the byte at the read index of the current packet, and rd_len is its length. rd_en advances the index, up to the length. rd_start or a release resets the index to byte 0.
- R11: With cfg_iso = 1, an rd_start while no packet is held sets uflow on the next cycle. With cfg_iso = 0 it does not.
- R12: uflow stays set until a uflow_clr pulse; a new underrun in the same cycle takes precedence over the clear. uflow_irq is uflow gated by cfg_irq_en.
- R13: flush or tx_done with the buffer empty changes nothing, including a partly filled packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_maxp | input | 7 | Maximum packet size in bytes |
| cfg_auto_commit | input | 1 | Commit a full-size packet without a commit pulse |
| cfg_iso | input | 1 | Isochronous mode, enables underrun detection |
| cfg_irq_en | input | 1 | Interrupt enable for the underrun flag |
| wr_en | input | 1 | Processor byte write strobe |
| wr_data | input | 8 | Processor byte |
| commit | input | 1 | Processor commit pulse (packet ready) |
| flush | input | 1 | Discard the older held packet |
| uflow_clr | input | 1 | Clear pulse for the underrun flag |
| rd_start | input | 1 | Serial engine requests a packet, rewinds the read index |
| rd_en | input | 1 | Advance the read index |
| tx_done | input | 1 | Current packet was sent and acknowledged |
| rd_data | output | 8 | Byte at the read index of the current packet |
| rd_len | output | 7 | Length of the current packet, 0 when empty |
| fill_level | output | 7 | Bytes written to the packet being assembled |
| not_empty | output | 1 | At least one committed packet is held |
| buf_full | output | 1 | Two committed packets are held |
| uflow | output | 1 | Sticky underrun flag |
| uflow_irq | output | 1 | Underrun interrupt request |

## Verification
Directed sequences cover several cases. Packets shorter than, equal to, and longer than the maximum size, each with auto-commit on and off, separate a size-triggered commit from a processor commit and from a discarded overflow byte. Flush and transmit-complete are each applied with zero, one and two packets held. This shows whether the older or the newer slot is released, and whether an empty release disturbs the partial fill. A randomized mix of writes, commits, flushes and completions, with a changing size limit, is compared against a two-entry queue model. Underrun is tried with isochronous mode off and on, and with the interrupt enable off and on.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

  function automatic int clamp_len(int req, int cap);
    return (req > cap) ? cap : req;
  endfunction

  function automatic bit hits_max(int filled, int maxp);
    return filled == maxp;
  endfunction

  function automatic logic [1:0] next_cnt(logic [1:0] cur, logic add, logic sub);
    return cur + {1'b0, add} - {1'b0, sub};
  endfunction

endpackage

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl #(
  parameter int MAX_BYTES = 64,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_maxp,
  input  logic          cfg_auto_commit,
  input  logic          wr_en,
  input  logic          commit,
  input  logic          flush,
  input  logic          tx_done,
  input  logic          rd_start,
  input  logic          rd_en,
  output logic          wr_acc,
  output logic          auto_hit,
  output logic          com_evt,
  output logic          rel_evt,
  output logic          wsel,
  output logic          head,
  output logic [1:0]    pkt_cnt,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] rd_idx,
  output logic [CW-1:0] head_len
);
  localparam logic [CW-1:0] CAP = CW'(MAX_BYTES);

  logic [1:0]    cnt_q;
  logic          wsel_q, head_q;
  logic [CW-1:0] fill_q, rdi_q;
  logic [CW-1:0] len_q [2];
  logic [CW-1:0] maxp_e, com_len;

  assign maxp_e   = CW'(pktbuf_pkg::clamp_len(int'(cfg_maxp), int'(CAP)));
  assign wr_acc   = wr_en && (cnt_q != 2'd2) && (fill_q < maxp_e);
  assign auto_hit = wr_acc && cfg_auto_commit &&
                    pktbuf_pkg::hits_max(int'(fill_q) + 1, int'(maxp_e));
  assign com_evt  = (commit || auto_hit) && (cnt_q != 2'd2);
  assign rel_evt  = (tx_done || flush) && (cnt_q != 2'd0);
  assign com_len  = fill_q + CW'(wr_acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wsel_q <= 1'b0;
      head_q <= 1'b0;
      fill_q <= '0;
      rdi_q  <= '0;
      for (int i = 0; i < 2; i++) len_q[i] <= '0;
    end else begin
      cnt_q <= pktbuf_pkg::next_cnt(cnt_q, com_evt, rel_evt);
      if (com_evt) begin
        len_q[wsel_q] <= com_len;
        wsel_q        <= ~wsel_q;
        fill_q        <= '0;
      end else if (wr_acc) begin
        fill_q <= fill_q + 1'b1;
      end
      if (rel_evt) head_q <= ~head_q;
      if (rel_evt || rd_start)
        rdi_q <= '0;
      else if (rd_en && (cnt_q != 2'd0) && (rdi_q < len_q[head_q]))
        rdi_q <= rdi_q + 1'b1;
    end
  end

  assign wsel     = wsel_q;
  assign head     = head_q;
  assign pkt_cnt  = cnt_q;
  assign fill     = fill_q;
  assign rd_idx   = rdi_q;
  assign head_len = len_q[head_q];
endmodule

// File: rtl/pktbuf_mem.sv
module pktbuf_mem #(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wsel,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rsel,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [1:0][DW-1:0] slot_rd;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic [DW-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wsel == 1'(g))) arr[waddr] <= wdata;
    end
    assign slot_rd[g] = arr[raddr];
  end

  assign rdata = slot_rd[rsel];
endmodule

// File: rtl/pktbuf_uflow.sv
module pktbuf_uflow (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
endmodule

// File: rtl/in_ep_pktbuf.sv
module in_ep_pktbuf #(
  parameter int DW = 8,
  parameter int MAX_BYTES = 64,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int AW = $clog2(MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_maxp,
  input  logic          cfg_auto_commit,
  input  logic          cfg_iso,
  input  logic          cfg_irq_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          flush,
  input  logic          uflow_clr,
  input  logic          rd_start,
  input  logic          rd_en,
  input  logic          tx_done,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rd_len,
  output logic [CW-1:0] fill_level,
  output logic          not_empty,
  output logic          buf_full,
  output logic          uflow,
  output logic          uflow_irq
);
  logic          wr_acc, auto_hit, com_evt, rel_evt, starve_evt;
  logic          wsel, head;
  logic [1:0]    pkt_cnt;
  logic [CW-1:0] fill, rd_idx, head_len;

  pktbuf_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk, .rst_n, .cfg_maxp, .cfg_auto_commit, .wr_en, .commit, .flush,
    .tx_done, .rd_start, .rd_en, .wr_acc, .auto_hit, .com_evt, .rel_evt,
    .wsel, .head, .pkt_cnt, .fill, .rd_idx, .head_len
  );

  pktbuf_mem #(.DW(DW), .DEPTH(MAX_BYTES)) u_mem (
    .clk, .we(wr_acc), .wsel, .waddr(fill[AW-1:0]), .wdata(wr_data),
    .rsel(head), .raddr(rd_idx[AW-1:0]), .rdata(rd_data)
  );

  assign starve_evt = rd_start && cfg_iso && (pkt_cnt == 2'd0);

  pktbuf_uflow u_uflow (
    .clk, .rst_n, .set_evt(starve_evt), .clr(uflow_clr), .irq_en(cfg_irq_en),
    .flag(uflow), .irq(uflow_irq)
  );

  assign not_empty  = (pkt_cnt != 2'd0);
  assign buf_full   = (pkt_cnt == 2'd2);
  assign fill_level = fill;
  assign rd_len     = not_empty ? head_len : '0;
endmodule

// File: rtl/pktbuf_chk.sv
module pktbuf_chk #(
  parameter int MAX_BYTES = 64,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_auto_commit,
  input logic          cfg_iso,
  input logic          flush,
  input logic          tx_done,
  input logic          rd_start,
  input logic          uflow_clr,
  input logic          wr_acc,
  input logic          com_evt,
  input logic          rel_evt,
  input logic [CW-1:0] cfg_maxp,
  input logic [CW-1:0] fill_level,
  input logic          not_empty,
  input logic          buf_full,
  input logic          uflow
);
  a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CW'(MAX_BYTES));

  a_r6_full_freezes_fill: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> fill_level == $past(fill_level));

  a_r4_auto_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && cfg_auto_commit && (fill_level + 1'b1 == cfg_maxp) &&
     (cfg_maxp <= CW'(MAX_BYTES))) |-> com_evt);

  a_r13_release_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |-> not_empty);

  a_r8_flush_keeps_newer: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && buf_full) |=> not_empty);

  a_r7_flush_one_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && not_empty && !buf_full && !com_evt) |=> !not_empty);

  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && not_empty && !buf_full && !com_evt) |=> !not_empty);

  a_r11_uflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uflow) |-> $past(rd_start && cfg_iso && !not_empty));

  a_r12_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !uflow_clr) |=> uflow);

  a_r12_uflow_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uflow) |-> $past(uflow_clr));
endmodule

bind in_ep_pktbuf pktbuf_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk, .rst_n, .cfg_auto_commit, .cfg_iso, .flush, .tx_done, .rd_start,
  .uflow_clr, .wr_acc, .com_evt, .rel_evt, .cfg_maxp, .fill_level,
  .not_empty, .buf_full, .uflow
);

// File: tb/in_ep_pktbuf_test.sv
module in_ep_pktbuf_test;
  localparam int MAXB = 64;
  localparam int CW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cfg_maxp = '0;
  logic cfg_auto_commit = 0, cfg_iso = 0, cfg_irq_en = 0;
  logic wr_en = 0, commit = 0, flush = 0, uflow_clr = 0;
  logic rd_start = 0, rd_en = 0, tx_done = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [CW-1:0] rd_len, fill_level;
  logic not_empty, buf_full, uflow, uflow_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  in_ep_pktbuf uut (.*);

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1; wr_data = b; tick(); wr_en = 0;
  endtask
  task automatic do_commit(); commit = 1; tick(); commit = 0; endtask
  task automatic do_flush();  flush = 1;  tick(); flush = 0;  endtask
  task automatic do_done();   tx_done = 1; tick(); tx_done = 0; endtask
  task automatic do_start();  rd_start = 1; tick(); rd_start = 0; endtask

  // bench model: two-entry queue plus partial fill
  int m_cnt, m_fill, m_maxp;
  bit m_auto;
  int q_len [2];
  logic [7:0] q_b0 [2];
  logic [7:0] f_b0;

  function automatic int eff_max(int req);
    return (req < MAXB) ? req : MAXB;
  endfunction

  function automatic bit wr_ok(int cnt, int fill, int maxp);
    return (cnt < 2) && (fill < eff_max(maxp));
  endfunction

  task automatic m_push();
    q_len[m_cnt] = m_fill; q_b0[m_cnt] = f_b0; m_cnt++; m_fill = 0;
  endtask
  task automatic m_pop();
    q_len[0] = q_len[1]; q_b0[0] = q_b0[1]; m_cnt--;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(20240611);
    repeat (3) tick();
    // R1
    chk("R1 not_empty", not_empty, 0); chk("R1 buf_full", buf_full, 0);
    chk("R1 uflow", uflow, 0); chk("R1 uflow_irq", uflow_irq, 0);
    chk("R1 fill", fill_level, 0);
    rst_n = 1; tick();

    // R3 short commit, R10 read port
    cfg_maxp = 8;
    for (int i = 0; i < 5; i++) wr(8'hA0 + 8'(i));
    chk("R3 uncommitted", not_empty, 0); chk("R3 fill", fill_level, 5);
    do_commit();
    chk("R2 not_empty", not_empty, 1); chk("R3 len", rd_len, 5);
    chk("R3 fill reset", fill_level, 0); chk("R10 byte0", rd_data, 8'hA0);
    for (int i = 1; i < 4; i++) begin
      rd_en = 1; tick(); rd_en = 0;
      chk("R10 byte", rd_data, 8'hA0 + i);
    end
    do_start(); chk("R10 rewind", rd_data, 8'hA0);

    // R4 auto commit at maxp
    cfg_maxp = 4; cfg_auto_commit = 1;
    for (int i = 0; i < 3; i++) wr(8'hD0 + 8'(i));
    chk("R4 before last", buf_full, 0);
    wr(8'hD3);
    chk("R4 auto full", buf_full, 1); chk("R4 fill", fill_level, 0);

    // R6 writes and commit ignored when full
    wr(8'h55); wr(8'h66);
    chk("R6 fill", fill_level, 0); chk("R6 full", buf_full, 1);
    do_commit();
    chk("R6 commit ignored", buf_full, 1); chk("R6 head len", rd_len, 5);

    // R8 flush with two
    do_flush();
    chk("R8 kept", not_empty, 1); chk("R8 full", buf_full, 0);
    chk("R8 len", rd_len, 4); chk("R8 data", rd_data, 8'hD0);
    // R7 flush with one
    do_flush(); chk("R7 empty", not_empty, 0);
    // R13 empty release leaves partial fill
    wr(8'hB0); wr(8'hB1);
    do_flush(); do_done();
    chk("R13 still empty", not_empty, 0); chk("R13 fill kept", fill_level, 2);
    // R3 short packet with auto on needs commit
    tick(); chk("R3 auto short", not_empty, 0);
    do_commit(); chk("R3 short len", rd_len, 2); chk("R3 data", rd_data, 8'hB0);

    // R5 overflow ignored without auto
    cfg_auto_commit = 0;
    for (int i = 0; i < 6; i++) wr(8'hC0 + 8'(i));
    chk("R5 fill capped", fill_level, 4); chk("R5 not committed", buf_full, 0);
    do_commit(); chk("R2 full", buf_full, 1);
    // R9 tx_done order
    do_done();
    chk("R9 len", rd_len, 4); chk("R9 data", rd_data, 8'hC0);
    rd_en = 1; repeat (3) tick(); rd_en = 0;
    chk("R10 byte3", rd_data, 8'hC3);
    do_done(); chk("R9 drained", not_empty, 0);

    // R11 / R12 underrun
    do_start(); chk("R11 non-iso", uflow, 0);
    cfg_iso = 1; do_start();
    chk("R11 iso set", uflow, 1); chk("R12 irq off", uflow_irq, 0);
    cfg_irq_en = 1; tick(); chk("R12 irq on", uflow_irq, 1);
    repeat (5) tick(); chk("R12 sticky", uflow, 1);
    rd_start = 1; uflow_clr = 1; tick(); rd_start = 0; uflow_clr = 0;
    chk("R12 set beats clear", uflow, 1);
    uflow_clr = 1; tick(); uflow_clr = 0;
    chk("R12 cleared", uflow, 0); chk("R12 irq drop", uflow_irq, 0);
    cfg_iso = 0;

    // random phase against queue model (R2 R4 R5 R6 R9)
    rst_n = 0; tick(); rst_n = 1;
    m_cnt = 0; m_fill = 0; f_b0 = '0;
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [7:0] b;
      if (it % 100 == 0) begin
        m_maxp = 1 + int'($urandom % 10); m_auto = 1'($urandom % 2);
        cfg_maxp = CW'(m_maxp); cfg_auto_commit = m_auto;
      end
      op = int'($urandom % 10);
      b = 8'($urandom);
      if (op < 6) begin
        wr(b);
        if (wr_ok(m_cnt, m_fill, m_maxp)) begin
          if (m_fill == 0) f_b0 = b;
          m_fill++;
          if (m_auto && m_fill == eff_max(m_maxp)) m_push();
        end
      end else if (op == 6) begin
        do_commit(); if (m_cnt < 2) m_push();
      end else if (op == 7) begin
        do_done(); if (m_cnt > 0) m_pop();
      end else if (op == 8) begin
        do_flush(); if (m_cnt > 0) m_pop();
      end else tick();
      chk("R2 rnd not_empty", not_empty, int'(m_cnt > 0));
      chk("R2 rnd full", buf_full, int'(m_cnt == 2));
      chk("R5 rnd fill", fill_level, m_fill);
      if (m_cnt > 0) begin
        chk("R9 rnd len", rd_len, q_len[0]);
        if (q_len[0] > 0) chk("R9 rnd data", rd_data, q_b0[0]);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule